// File: doc/BRIEF.md
# Power-Bus Command Master

This block lets a processor reach the registers of on-chip power and reset slave units through a small memory-mapped window. Software stores the data it wants written, programs a cycle budget, and then writes one control word. That word carries a launch bit, a read/write select, an 8-bit slave address and a word offset. The block turns the control word into a single request on an internal management bus and then waits for the slave to answer.

The same control word reports the result. While the transfer is in flight, the launch bit and a busy bit both read as one. The block clears them when the slave acknowledges, when the slave signals an error, or when the programmed cycle budget runs out. The block then sets a slave-error flag or a timeout flag when the transfer failed. On a successful read, the slave's data can be fetched from a read-data register.

The sequencer has three states. IDLE waits for a launch. ISSUE drives the one-cycle request. WAIT counts down the budget and watches for a response. Its transitions are: IDLE→ISSUE on launch, ISSUE→WAIT unconditionally, WAIT→IDLE on slave error, WAIT→IDLE on acknowledge, and WAIT→IDLE on expiry.

Top module: `pwrbus_master`

## Requirements
- R1: After reset, the control, write-data and read-data registers read 0, and the timeout register reads its reset value TMO_RESET (default 1000).
- R2: `cpu_widx` selects a register. Index 0 is control, 1 is write data, 2 is the cycle budget (low TMO_W bits) and 3 is read data. The write-data and budget registers read back what was written. In the control word, bit 31 is launch, bit 30 is the timeout flag, bit 29 is the slave-error flag, bit 28 is busy, bit 20 is the operation (1 = write, 0 = read), bits 19:12 are the slave address and bits 11:0 are the word offset. Bits 27:21 read 0.
- R3: A control write with bit 31 set while not busy starts a transfer. From the next cycle, bits 31 and 28 read 1 and both flags read 0. In that same cycle, `sl_req` is high for exactly one cycle, carrying the address, offset and operation from the control word and the contents of the write-data register.
- R4: When the slave asserts `sl_ack` in the k-th cycle after the request cycle, bits 31 and 28 read 0 from the following cycle. For a read, the read-data register then holds `sl_rdata`. For a write, the read-data register is unchanged.
- R5: When the slave asserts `sl_err`, bit 29 reads 1 and bits 31 and 28 clear with the same timing as in R4. The read-data register is unchanged.
- R6: With budget T, the slave may respond in any of the first T+1 cycles after the request cycle. If it has not responded by then, bit 30 reads 1 and bits 31 and 28 read 0 from the T+2-th cycle after the request cycle. The read-data register is unchanged.
- R7: When responses coincide, `sl_err` wins over `sl_ack`. Either response arriving in the last budget cycle wins over the timeout.
- R8: A control write while busy has no effect. The stored address, offset and operation are kept, and no further request is issued.
- R9: A control write with bit 31 clear while idle updates only the stored address, offset and operation. It issues no request and leaves both flags as they were.
- R10: Writes to index 3 are ignored, and the read-data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 = write access, 0 = read |
| cpu_widx | input | 2 | Register index (byte offset / 4) |
| cpu_wdata | input | 32 | Write data from the processor |
| cpu_rdata | output | 32 | Read data for the selected register |
| sl_req | output | 1 | One-cycle request to the slave |
| sl_write | output | 1 | Request is a write |
| sl_addr | output | 8 | Target slave address |
| sl_off | output | 12 | Register word offset in the slave |
| sl_wdata | output | 32 | Data for a write request |
| sl_ack | input | 1 | Slave completed the request |
| sl_err | input | 1 | Slave rejected the request |
| sl_rdata | input | 32 | Data returned by the slave, sampled with `sl_ack` |

## Verification
Two pairs of events can land in the same cycle. The first pair is a slave response and the expiry of the cycle budget. The bench provokes it by setting the slave latency to exactly T+1 (the response must win) and to T+2 (the timeout must win). The second pair is acknowledge and error together, which the slave model raises in one cycle; the error flag must win and the read data must be left alone. Each outcome is judged from the flags, the cycle in which the launch bit clears, and the read-data register.

// File: rtl/pwrbus_pkg.sv
package pwrbus_pkg;

    localparam int DATA_W    = 32;
    localparam int IDX_W     = 2;
    localparam int SADDR_W   = 8;
    localparam int OFF_W     = 12;

    localparam int START_BIT = 31;
    localparam int TMO_BIT   = 30;
    localparam int SERR_BIT  = 29;
    localparam int BUSY_BIT  = 28;
    localparam int OP_BIT    = 20;
    localparam int SADDR_LSB = 12;

    localparam logic [IDX_W-1:0] IDX_CTRL  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_WDATA = 2'd1;
    localparam logic [IDX_W-1:0] IDX_TMO   = 2'd2;
    localparam logic [IDX_W-1:0] IDX_RDATA = 2'd3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic               wr;
        logic [SADDR_W-1:0] saddr;
        logic [OFF_W-1:0]   off;
    } cmd_t;

endpackage

// File: rtl/pwrbus_timer.sv
module pwrbus_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwrbus_seq.sv
module pwrbus_seq
    import pwrbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic sl_ack,
    input  logic sl_err,
    input  logic tmr_expired,
    output logic tmr_load,
    output logic tmr_run,
    output logic sl_req,
    output logic busy,
    output logic done_ok,
    output logic done_err,
    output logic done_tmo
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        sl_req   = 1'b0;
        done_ok  = 1'b0;
        done_err = 1'b0;
        done_tmo = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (launch) begin
                    tmr_load = 1'b1;
                    state_d  = SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                sl_req  = 1'b1;
                state_d = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                tmr_run = 1'b1;
                if (sl_err) begin
                    done_err = 1'b1;
                    state_d  = SEQ_IDLE;
                end else if (sl_ack) begin
                    done_ok = 1'b1;
                    state_d = SEQ_IDLE;
                end else if (tmr_expired) begin
                    done_tmo = 1'b1;
                    state_d  = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    assign busy = (state_q != SEQ_IDLE);
endmodule

// File: rtl/pwrbus_regs.sv
module pwrbus_regs
    import pwrbus_pkg::*;
#(
    parameter int          TMO_W     = 16,
    parameter int unsigned TMO_RESET = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [IDX_W-1:0]  cpu_widx,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              busy,
    input  logic              done_ok,
    input  logic              done_err,
    input  logic              done_tmo,
    input  logic [DATA_W-1:0] sl_rdata,
    output logic              launch,
    output cmd_t              cmd,
    output logic [DATA_W-1:0] wdata_q,
    output logic [TMO_W-1:0]  tmo_q,
    output logic              flag_tmo,
    output logic              flag_serr
);
    logic [DATA_W-1:0] rd_q;
    logic              wr_any;
    logic              ctrl_wr_en;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_any     = cpu_sel && cpu_wr;
    assign ctrl_wr_en = wr_any && (cpu_widx == IDX_CTRL) && !busy;
    assign launch     = ctrl_wr_en && cpu_wdata[START_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd       <= '0;
            wdata_q   <= '0;
            tmo_q     <= TMO_W'(TMO_RESET);
            rd_q      <= '0;
            flag_tmo  <= 1'b0;
            flag_serr <= 1'b0;
        end else begin
            if (ctrl_wr_en) begin
                cmd.wr    <= cpu_wdata[OP_BIT];
                cmd.saddr <= cpu_wdata[SADDR_LSB +: SADDR_W];
                cmd.off   <= cpu_wdata[OFF_W-1:0];
            end
            if (launch) begin
                flag_tmo  <= 1'b0;
                flag_serr <= 1'b0;
            end
            if (done_err) begin
                flag_serr <= 1'b1;
            end
            if (done_tmo) begin
                flag_tmo <= 1'b1;
            end
            if (done_ok && !cmd.wr) begin
                rd_q <= sl_rdata;
            end
            if (wr_any && (cpu_widx == IDX_WDATA)) begin
                wdata_q <= cpu_wdata;
            end
            if (wr_any && (cpu_widx == IDX_TMO)) begin
                tmo_q <= cpu_wdata[TMO_W-1:0];
            end
        end
    end

    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[START_BIT]               = busy;
        ctrl_word[TMO_BIT]                 = flag_tmo;
        ctrl_word[SERR_BIT]                = flag_serr;
        ctrl_word[BUSY_BIT]                = busy;
        ctrl_word[OP_BIT]                  = cmd.wr;
        ctrl_word[SADDR_LSB +: SADDR_W]    = cmd.saddr;
        ctrl_word[OFF_W-1:0]               = cmd.off;
    end

    always_comb begin
        unique case (cpu_widx)
            IDX_CTRL:  cpu_rdata = ctrl_word;
            IDX_WDATA: cpu_rdata = wdata_q;
            IDX_TMO:   cpu_rdata = DATA_W'(tmo_q);
            IDX_RDATA: cpu_rdata = rd_q;
            default:   cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwrbus_master.sv
module pwrbus_master
    import pwrbus_pkg::*;
#(
    parameter int          TMO_W     = 16,
    parameter int unsigned TMO_RESET = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_sel,
    input  logic                cpu_wr,
    input  logic [IDX_W-1:0]    cpu_widx,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                sl_req,
    output logic                sl_write,
    output logic [SADDR_W-1:0]  sl_addr,
    output logic [OFF_W-1:0]    sl_off,
    output logic [DATA_W-1:0]   sl_wdata,
    input  logic                sl_ack,
    input  logic                sl_err,
    input  logic [DATA_W-1:0]   sl_rdata
);
    logic             launch;
    logic             busy;
    logic             done_ok;
    logic             done_err;
    logic             done_tmo;
    logic             tmr_load;
    logic             tmr_run;
    logic             tmr_expired;
    logic             flag_tmo;
    logic             flag_serr;
    cmd_t             cmd;
    logic [TMO_W-1:0] tmo_q;
    logic [DATA_W-1:0] wdata_q;

    pwrbus_regs #(
        .TMO_W     (TMO_W),
        .TMO_RESET (TMO_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_widx  (cpu_widx),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .busy      (busy),
        .done_ok   (done_ok),
        .done_err  (done_err),
        .done_tmo  (done_tmo),
        .sl_rdata  (sl_rdata),
        .launch    (launch),
        .cmd       (cmd),
        .wdata_q   (wdata_q),
        .tmo_q     (tmo_q),
        .flag_tmo  (flag_tmo),
        .flag_serr (flag_serr)
    );

    pwrbus_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .sl_ack      (sl_ack),
        .sl_err      (sl_err),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_run     (tmr_run),
        .sl_req      (sl_req),
        .busy        (busy),
        .done_ok     (done_ok),
        .done_err    (done_err),
        .done_tmo    (done_tmo)
    );

    pwrbus_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmo_q),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    assign sl_write = cmd.wr;
    assign sl_addr  = cmd.saddr;
    assign sl_off   = cmd.off;
    assign sl_wdata = wdata_q;
endmodule

// File: rtl/pwrbus_master_chk.sv
module pwrbus_master_chk
    import pwrbus_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sl_req,
    input logic             sl_ack,
    input logic             sl_err,
    input logic             cpu_sel,
    input logic             cpu_wr,
    input logic [IDX_W-1:0] cpu_widx,
    input logic             flag_tmo,
    input logic             flag_serr,
    input cmd_t             cmd
);
    logic ctrl_wr;
    assign ctrl_wr = cpu_sel && cpu_wr && (cpu_widx == IDX_CTRL);

    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        sl_req |=> !sl_req);

    a_r3_req_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sl_req);

    a_r3_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sl_req);

    a_r3_launch_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!flag_tmo && !flag_serr));

    a_r4_ack_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sl_req && sl_ack) |=> !busy);

    a_r5_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sl_req && sl_err) |=> (flag_serr && !busy));

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_tmo && flag_serr));

    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> $stable(cmd));
endmodule

bind pwrbus_master pwrbus_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sl_req    (sl_req),
    .sl_ack    (sl_ack),
    .sl_err    (sl_err),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_widx  (cpu_widx),
    .flag_tmo  (flag_tmo),
    .flag_serr (flag_serr),
    .cmd       (cmd)
);

// File: tb/pwrbus_master_bench.sv
`timescale 1ns/1ps
module pwrbus_master_bench;
    localparam int TMO_RESET = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_widx = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        sl_req, sl_write, sl_ack, sl_err;
    logic [7:0]  sl_addr;
    logic [11:0] sl_off;
    logic [31:0] sl_wdata, sl_rdata;

    always #4 clk = ~clk;

    pwrbus_master #(.TMO_W(16), .TMO_RESET(TMO_RESET)) u_pwrbus_master (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_widx(cpu_widx), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sl_req(sl_req), .sl_write(sl_write), .sl_addr(sl_addr), .sl_off(sl_off),
        .sl_wdata(sl_wdata), .sl_ack(sl_ack), .sl_err(sl_err), .sl_rdata(sl_rdata)
    );

    // behavioural slave: mode 0 ack, 1 error, 2 silent, 3 ack+error together
    int          slv_lat = 1;
    int          slv_mode = 0;
    logic [31:0] slv_rd = '0;
    int          scnt;
    int          req_count;
    logic [7:0]  cap_addr;
    logic [11:0] cap_off;
    logic        cap_wr;
    logic [31:0] cap_wdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt <= 0; req_count <= 0;
            cap_addr <= '0; cap_off <= '0; cap_wr <= 1'b0; cap_wdata <= '0;
        end else if (sl_req) begin
            scnt <= slv_lat; req_count <= req_count + 1;
            cap_addr <= sl_addr; cap_off <= sl_off; cap_wr <= sl_write; cap_wdata <= sl_wdata;
        end else if (scnt > 0) begin
            scnt <= scnt - 1;
        end
    end
    assign sl_ack   = (scnt == 1) && (slv_mode == 0 || slv_mode == 3);
    assign sl_err   = (scnt == 1) && (slv_mode == 1 || slv_mode == 3);
    assign sl_rdata = slv_rd;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_rd = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_widx = idx; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] d);
        cpu_widx = idx; cpu_sel = 1'b1; cpu_wr = 1'b0;
        #1;
        d = cpu_rdata;
        cpu_sel = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_cmd(input bit start, input bit op,
                                             input logic [7:0] a, input logic [11:0] o);
        return {start, 10'b0, op, a, o};
    endfunction

    // 0 = success, 1 = slave error, 2 = timeout
    function automatic int outcome(input int mode, input int lat, input int t);
        if (mode == 2 || lat > t + 1) return 2;
        if (mode == 0) return 0;
        return 1;
    endfunction

    task automatic xfer(input bit op, input logic [7:0] a, input logic [11:0] o,
                        input logic [31:0] wd, input int t, input int lat, input int mode);
        logic [31:0] v;
        int base, k, kind, k_exp;
        wr(2'd1, wd);
        wr(2'd2, 32'(t));
        slv_lat = lat; slv_mode = mode; slv_rd = $urandom;
        base = req_count;
        wr(2'd0, ctrl_cmd(1'b1, op, a, o));
        rd(2'd0, v);
        chk(v[31] && v[28] && !v[30] && !v[29], "R3 launch status", v, 32'h9000_0000);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            rd(2'd0, v);
        end while (v[31] && k < 60);
        kind  = outcome(mode, lat, t);
        k_exp = (kind == 2) ? t + 2 : lat + 1;
        if (kind == 0 && !op) exp_rd = slv_rd;
        chk(k == k_exp, (kind == 2) ? "R6 cycles to timeout" : "R4 cycles to completion", 32'(k), 32'(k_exp));
        chk(v[30] == (kind == 2) && v[29] == (kind == 1) && !v[28],
            (kind == 1) ? "R5/R7 error flag" : "R6/R7 timeout flag",
            v, {1'b0, kind == 2, kind == 1, 29'b0});
        chk(cap_addr == a && cap_off == o && cap_wr == op && (!op || cap_wdata == wd),
            "R3 request fields", {cap_wr, 11'b0, cap_addr, cap_off}, {op, 11'b0, a, o});
        chk(req_count == base + 1, "R3 single request", 32'(req_count), 32'(base + 1));
        rd(2'd3, v);
        chk(v == exp_rd, "R4/R5/R6 read data", v, exp_rd);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 control reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 write data reset", v, 0);
        rd(2'd2, v); chk(v == TMO_RESET, "R1 budget reset", v, TMO_RESET);
        rd(2'd3, v); chk(v == 0, "R1 read data reset", v, 0);
        // R2 readback
        wr(2'd1, 32'hCAFE_F00D); rd(2'd1, v); chk(v == 32'hCAFE_F00D, "R2 write data readback", v, 32'hCAFE_F00D);
        wr(2'd2, 32'h0001_0007); rd(2'd2, v); chk(v == 32'h7, "R2 budget low bits", v, 32'h7);
        // R9 idle write without launch
        wr(2'd0, ctrl_cmd(1'b0, 1'b1, 8'hA5, 12'h3C1) | 32'h0FE0_0000);
        rd(2'd0, v); chk(v == ctrl_cmd(1'b0, 1'b1, 8'hA5, 12'h3C1), "R9/R2 fields only", v, ctrl_cmd(1'b0, 1'b1, 8'hA5, 12'h3C1));
        chk(req_count == 0, "R9 no request", 32'(req_count), 0);
        // directed boundaries
        xfer(1'b0, 8'h11, 12'h004, 32'h0, 3, 4, 0);   // R6 last cycle ack wins
        xfer(1'b0, 8'h12, 12'h008, 32'h0, 3, 5, 0);   // R6 one cycle late
        xfer(1'b1, 8'h13, 12'h00C, 32'h1234_5678, 0, 1, 0);
        xfer(1'b0, 8'h14, 12'h010, 32'h0, 0, 2, 0);
        xfer(1'b0, 8'h15, 12'h014, 32'h0, 2, 3, 1);   // R7 error in last cycle
        xfer(1'b0, 8'h16, 12'h018, 32'h0, 5, 2, 3);   // R7 error beats ack
        xfer(1'b0, 8'h17, 12'h01C, 32'h0, 4, 1, 2);   // silent slave
        // R9 flags kept after timeout
        wr(2'd0, ctrl_cmd(1'b0, 1'b0, 8'h5A, 12'h0F0));
        rd(2'd0, v); chk(v == (ctrl_cmd(1'b0, 1'b0, 8'h5A, 12'h0F0) | 32'h4000_0000), "R9 flag kept", v,
                         ctrl_cmd(1'b0, 1'b0, 8'h5A, 12'h0F0) | 32'h4000_0000);
        // R10 read data write ignored
        wr(2'd3, 32'hDEAD_BEEF); rd(2'd3, v); chk(v == exp_rd, "R10 read data write ignored", v, exp_rd);
        // R8 control write while busy
        begin
            int base;
            wr(2'd2, 32'd20);
            slv_lat = 6; slv_mode = 0; slv_rd = 32'h0BAD_CAFE;
            base = req_count;
            wr(2'd0, ctrl_cmd(1'b1, 1'b0, 8'h33, 12'h044));
            wr(2'd0, ctrl_cmd(1'b1, 1'b1, 8'hCC, 12'hBBB));
            rd(2'd0, v); chk(v[19:0] == 20'h33044 && !v[20], "R8 fields kept while busy", v, ctrl_cmd(1'b1, 1'b0, 8'h33, 12'h044) | 32'h1000_0000);
            repeat (15) @(negedge clk);
            exp_rd = 32'h0BAD_CAFE;
            chk(req_count == base + 1, "R8 no second request", 32'(req_count), 32'(base + 1));
            rd(2'd3, v); chk(v == exp_rd, "R8/R4 original read completed", v, exp_rd);
            repeat (10) @(negedge clk);
        end
        // constrained random
        for (int i = 0; i < 40; i++) begin
            int r, m;
            r = int'($urandom % 10);
            m = (r < 6) ? 0 : (r < 8) ? 1 : (r == 8) ? 2 : 3;
            xfer(1'($urandom), 8'($urandom), 12'($urandom), $urandom,
                 int'($urandom % 7), 1 + int'($urandom % 9), m);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule